// File: doc/BRIEF.md
# Configurable External Interrupt Sense Controller

The block watches a parameterised group of external interrupt pins. Each pin passes through a two-flop synchroniser. A per-pin sense field then selects one condition on the synchronised level: low level, high level, rising edge, falling edge, or either edge. When the chosen condition occurs, the pin's detect bit latches. A per-pin enable gates that bit onto a dedicated interrupt output line.

Software reaches the block over a plain 32-bit register bus with a read strobe, a write strobe, a byte address and write data. Through this bus it can:
- read pending requests, the detect bits and the raw synchronised pin levels;
- turn enables on and off through two write-one registers;
- clear detect bits with write-one-to-clear;
- program one configuration word per pin.

Read data is combinational in the cycle the read strobe is high. Bit n of every status and enable register belongs to pin n. Register bits at or above the pin count read as zero.

Top module: `ext_irq_sense`

## Requirements
- R1: After reset, all enables, detect bits and configuration words are zero, every interrupt output is low, and the request (0x00), enable (0x04) and detect (0x100) registers read zero.
- R2: Offset 0x104 reads the pin levels after a two-flop synchroniser. A pin change driven between clock edges is not visible after the first rising edge and is visible after the second.
- R3: A sense field of 0x01 latches the detect bit while the synchronised pin is low. A sense field of 0x02 latches it while the pin is high.
- R4: A sense field of 0x08 latches on a rising edge of the synchronised pin, 0x04 on a falling edge, and 0x0C on either edge. An edge-mode pin that holds steady latches nothing.
- R5: Any sense field value other than 0x01, 0x02, 0x04, 0x08 and 0x0C detects nothing.
- R6: Writing offset 0x08 turns on the enable of each pin whose data bit is 1. Zero bits and bits at or above the pin count have no effect. A read of 0x08 returns zero.
- R7: Writing offset 0x04 turns off the enable of each pin whose data bit is 1. A read of 0x04 returns the current enables.
- R8: Offset 0x100 reads the detect bits. Writing a 1 to a bit clears it. A detect bit never falls without such a write. In an edge mode, a cleared bit stays clear until a new edge arrives.
- R9: In a level mode, when a clear is written while the pin still sits at the active level, the bit reads 0 in the cycle after the write and 1 again one clock later.
- R10: Offset 0x00 reads detect AND enable, and output irq_o[n] is high exactly when that bit n is 1.
- R11: Pin n's configuration word sits at 0x180 + 4*n and keeps all 32 written bits, of which bits 5:0 are the sense field. Words for n at or above the pin count read zero and ignore writes.
- R12: Reads of any other offset, including addresses with nonzero bits 1:0, return zero. Writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | NPINS | External interrupt pins, asynchronous |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, zero when bus_rd is low |
| irq_o | output | NPINS | Per-pin interrupt outputs, detect AND enable |

## Verification
The assertions check four rules on every cycle:
- an interrupt output is never high without both its enable and its detect bit;
- a detect bit never falls except on a clear write;
- an enable-set or enable-clear write takes effect on the next edge;
- misaligned reads return zero.

Only the bench's scenarios can show the behaviour that depends on programmed history:
- the decoding of each sense code against level and edge stimuli;
- the rejection of unlisted codes;
- the exact two-edge synchroniser latency;
- the one-cycle dip and re-set of a level-mode detect bit after a clear;
- configuration words keeping their upper bits.

// File: rtl/irqs_pkg.sv
package irqs_pkg;
    localparam int SENSE_W = 6;
    localparam int DATA_W  = 32;

    localparam logic [8:0] OFS_REQ  = 9'h000;
    localparam logic [8:0] OFS_ENCL = 9'h004;
    localparam logic [8:0] OFS_ENST = 9'h008;
    localparam logic [8:0] OFS_DET  = 9'h100;
    localparam logic [8:0] OFS_MON  = 9'h104;
    localparam logic [8:0] OFS_CFG  = 9'h180;

    localparam logic [SENSE_W-1:0] SN_LOW  = 6'h01;
    localparam logic [SENSE_W-1:0] SN_HIGH = 6'h02;
    localparam logic [SENSE_W-1:0] SN_FALL = 6'h04;
    localparam logic [SENSE_W-1:0] SN_RISE = 6'h08;
    localparam logic [SENSE_W-1:0] SN_BOTH = 6'h0C;
endpackage

// File: rtl/irqs_sync.sv
module irqs_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = async_i;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_o = st_q.s2;
endmodule

// File: rtl/irqs_hit.sv
module irqs_hit
    import irqs_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NPINS-1:0]              lvl_i,
    input  logic [NPINS-1:0][SENSE_W-1:0] sense_i,
    output logic [NPINS-1:0]              lvl_hit_o,
    output logic [NPINS-1:0]              edg_hit_o
);
    logic [NPINS-1:0] prev_d, prev_q;

    always_comb prev_d = lvl_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end

    for (genvar g = 0; g < NPINS; g++) begin : g_pin
        logic rise, fall;
        assign rise = lvl_i[g] & ~prev_q[g];
        assign fall = ~lvl_i[g] & prev_q[g];
        always_comb begin
            lvl_hit_o[g] = 1'b0;
            edg_hit_o[g] = 1'b0;
            unique case (sense_i[g])
                SN_LOW:  lvl_hit_o[g] = ~lvl_i[g];
                SN_HIGH: lvl_hit_o[g] = lvl_i[g];
                SN_FALL: edg_hit_o[g] = fall;
                SN_RISE: edg_hit_o[g] = rise;
                SN_BOTH: edg_hit_o[g] = rise | fall;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/ext_irq_sense.sv
module ext_irq_sense
    import irqs_pkg::*;
#(
    parameter int NPINS  = 32,
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NPINS-1:0]  pin_i,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [NPINS-1:0]  irq_o
);
    localparam int CFG_W = DATA_W;

    typedef struct packed {
        logic [NPINS-1:0]            en;
        logic [NPINS-1:0]            det;
        logic [NPINS-1:0][CFG_W-1:0] cfg;
    } state_t;

    state_t st_d, st_q;

    logic [NPINS-1:0]              lvl_sync;
    logic [NPINS-1:0]              lvl_hit, edg_hit;
    logic [NPINS-1:0][SENSE_W-1:0] sense;
    logic [NPINS-1:0]              req;

    irqs_sync #(.W(NPINS)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pin_i),
        .sync_o  (lvl_sync)
    );

    for (genvar g = 0; g < NPINS; g++) begin : g_sense
        assign sense[g] = st_q.cfg[g][SENSE_W-1:0];
    end

    irqs_hit #(.NPINS(NPINS)) u_hit (
        .clk       (clk),
        .rst_n     (rst_n),
        .lvl_i     (lvl_sync),
        .sense_i   (sense),
        .lvl_hit_o (lvl_hit),
        .edg_hit_o (edg_hit)
    );

    assign req   = st_q.det & st_q.en;
    assign irq_o = req;

    // next-state: register writes, detect latching
    always_comb begin
        logic [NPINS-1:0] en_set, en_clr, det_clr;
        st_d    = st_q;
        en_set  = '0;
        en_clr  = '0;
        det_clr = '0;
        if (bus_wr) begin
            if (bus_addr == ADDR_W'(OFS_ENST)) en_set  = bus_wdata[NPINS-1:0];
            if (bus_addr == ADDR_W'(OFS_ENCL)) en_clr  = bus_wdata[NPINS-1:0];
            if (bus_addr == ADDR_W'(OFS_DET))  det_clr = bus_wdata[NPINS-1:0];
            for (int i = 0; i < NPINS; i++) begin
                if (bus_addr == ADDR_W'(OFS_CFG + 4 * i)) st_d.cfg[i] = bus_wdata;
            end
        end
        st_d.en  = (st_q.en & ~en_clr) | en_set;
        // edge hits survive a same-cycle clear; level hits yield to it
        st_d.det = edg_hit | ((st_q.det | lvl_hit) & ~det_clr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // read mux
    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            if (bus_addr == ADDR_W'(OFS_REQ))  bus_rdata = 32'(req);
            if (bus_addr == ADDR_W'(OFS_ENCL)) bus_rdata = 32'(st_q.en);
            if (bus_addr == ADDR_W'(OFS_DET))  bus_rdata = 32'(st_q.det);
            if (bus_addr == ADDR_W'(OFS_MON))  bus_rdata = 32'(lvl_sync);
            for (int i = 0; i < NPINS; i++) begin
                if (bus_addr == ADDR_W'(OFS_CFG + 4 * i)) bus_rdata = st_q.cfg[i];
            end
        end
    end
endmodule

// File: rtl/irqs_chk.sv
module irqs_chk
    import irqs_pkg::*;
#(
    parameter int NPINS  = 32,
    parameter int ADDR_W = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic [NPINS-1:0]  irq_o,
    input logic [NPINS-1:0]  en_q,
    input logic [NPINS-1:0]  det_q
);
    // R10
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_o & ~en_q) == '0) && ((irq_o & ~det_q) == '0));

    // R6
    en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(OFS_ENST)) |=>
        ((en_q & $past(bus_wdata[NPINS-1:0])) == $past(bus_wdata[NPINS-1:0])));

    // R7
    en_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(OFS_ENCL)) |=>
        ((en_q & $past(bus_wdata[NPINS-1:0])) == '0));

    // R8
    det_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == ADDR_W'(OFS_DET)) |=>
        (($past(det_q) & ~det_q) == '0));

    // R12
    misalign_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr[1:0] != 2'b00) |-> (bus_rdata == 32'h0));
endmodule

bind ext_irq_sense irqs_chk #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_o     (irq_o),
    .en_q      (st_q.en),
    .det_q     (st_q.det)
);

// File: tb/sim_ext_irq_sense.sv
`timescale 1ns/1ps
module sim_ext_irq_sense;
    localparam int N  = 6;
    localparam int AW = 9;
    localparam logic [31:0] MASK = 32'h3F;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  pin_i = '0;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [N-1:0]  irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    ext_irq_sense #(.NPINS(N), .ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_o(irq_o)
    );

    // {sense code[5:0], start level, end level, expected detect}
    localparam int NV = 13;
    localparam logic [8:0] VEC [NV] = '{
        {6'h01, 1'b1, 1'b0, 1'b1},
        {6'h01, 1'b1, 1'b1, 1'b0},
        {6'h02, 1'b0, 1'b1, 1'b1},
        {6'h02, 1'b0, 1'b0, 1'b0},
        {6'h04, 1'b1, 1'b0, 1'b1},
        {6'h04, 1'b0, 1'b1, 1'b0},
        {6'h08, 1'b0, 1'b1, 1'b1},
        {6'h08, 1'b1, 1'b0, 1'b0},
        {6'h0C, 1'b0, 1'b1, 1'b1},
        {6'h0C, 1'b1, 1'b0, 1'b1},
        {6'h03, 1'b0, 1'b1, 1'b0},
        {6'h00, 1'b1, 1'b0, 1'b0},
        {6'h10, 1'b0, 1'b1, 1'b0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk);
        #1 bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic set_pin(input int idx, input logic v);
        @(negedge clk);
        pin_i[idx] = v;
    endtask

    initial begin
        logic [31:0] d;
        string tag;
        wait_cyc(3);
        #1 rst_n = 1'b1;

        // R1 reset state
        rd(9'h000, d); check("R1 req", d, 0);
        rd(9'h004, d); check("R1 en", d, 0);
        rd(9'h100, d); check("R1 det", d, 0);
        rd(9'h180, d); check("R1 cfg0", d, 0);
        check("R1 irq", 32'(irq_o), 0);

        // R2 synchroniser latency
        @(negedge clk) pin_i = 6'b101100;
        @(posedge clk); #1;
        rd(9'h104, d); check("R2 one edge", d, 0);
        rd(9'h104, d); check("R2 two edges", d, 32'h2C);
        @(negedge clk) pin_i = '0;
        wait_cyc(4);
        wr(9'h100, MASK);

        // R6 / R7 enable set and clear
        wr(9'h008, 32'h05); rd(9'h004, d); check("R6 set", d, 32'h05);
        wr(9'h008, 32'h02); rd(9'h004, d); check("R6 zeros keep", d, 32'h07);
        rd(9'h008, d); check("R6 read zero", d, 0);
        wr(9'h004, 32'h04); rd(9'h004, d); check("R7 clear", d, 32'h03);
        wr(9'h008, 32'hFFFF_FFC0); rd(9'h004, d); check("R6 high bits", d, 32'h03);
        wr(9'h004, MASK); rd(9'h004, d); check("R7 clear all", d, 0);

        // R3 R4 R5 sense table on pin 0
        for (int k = 0; k < NV; k++) begin
            logic [5:0] code;
            logic s, e, x;
            {code, s, e, x} = VEC[k];
            if (code == 6'h01 || code == 6'h02) tag = "R3";
            else if (code == 6'h04 || code == 6'h08 || code == 6'h0C) tag = "R4";
            else tag = "R5";
            set_pin(0, s);
            wait_cyc(6);
            wr(9'h180, {26'h0, code});
            wr(9'h100, 32'h1);
            wait_cyc(2);
            rd(9'h100, d); check($sformatf("R8 pre row %0d", k), d & 1, 0);
            set_pin(0, e);
            wait_cyc(6);
            rd(9'h100, d); check($sformatf("%s row %0d", tag, k), d & 1, {31'h0, x});
        end

        // R10 gating
        wr(9'h184, 32'h02);
        set_pin(1, 1'b1);
        wait_cyc(6);
        wr(9'h008, 32'h02);
        rd(9'h000, d); check("R10 req", d, 32'h02);
        check("R10 irq on", 32'(irq_o), 32'h02);
        wr(9'h004, 32'h02);
        rd(9'h000, d); check("R10 req masked", d, 0);
        check("R10 irq off", 32'(irq_o), 0);
        rd(9'h100, d); check("R10 det kept", d & 2, 2);

        // R9 level re-set after clear
        wr(9'h008, 32'h02);
        wr(9'h100, 32'h02);
        rd(9'h100, d); check("R9 dip", d & 2, 0);
        check("R9 irq dip", 32'(irq_o) & 2, 0);
        @(posedge clk); #1;
        rd(9'h100, d); check("R9 reset", d & 2, 2);

        // R8 edge mode stays clear
        wr(9'h188, 32'h08);
        set_pin(2, 1'b1);
        wait_cyc(6);
        rd(9'h100, d); check("R8 edge set", d & 4, 4);
        wr(9'h100, 32'h04);
        wait_cyc(10);
        rd(9'h100, d); check("R8 stays clear", d & 4, 0);
        set_pin(2, 1'b0); wait_cyc(6);
        set_pin(2, 1'b1); wait_cyc(6);
        rd(9'h100, d); check("R8 new edge", d & 4, 4);

        // R11 config words
        wr(9'h18C, 32'hABCD_EF00);
        rd(9'h18C, d); check("R11 keep bits", d, 32'hABCD_EF00);
        wr(9'h198, 32'h1234_5678);
        rd(9'h198, d); check("R11 beyond N", d, 0);

        // R12 unmapped
        rd(9'h10C, d); check("R12 unmapped", d, 0);
        rd(9'h181, d); check("R12 misaligned", d, 0);
        wr(9'h00C, MASK); wr(9'h00A, MASK);
        rd(9'h004, d); check("R12 write ignored", d, 32'h02);
        rd(9'h184, d); check("R12 cfg unchanged", d, 32'h02);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule